// File: doc/BRIEF.md
# Quad-Tree Split and Mode Selector

This block picks the coding-unit partition and the intra prediction mode for one 32x32 region of a picture. It works only from estimated distortion costs that an upstream estimator streams in. It never looks at the reconstructed picture, so its result is final before the encoding of the region starts. For each candidate coding unit it receives one cost for every one of the 35 intra modes and keeps the cheapest. It works from the bottom up. Each 16x16 unit is weighed against its four 8x8 children, and then the 32x32 unit is weighed against the best structure found inside each of its four quadrants.

The candidates arrive in a fixed post-order walk. Each quadrant is visited in Z order: its four 8x8 units come first and the 16x16 unit follows. The 32x32 unit comes last of all. Child results are held inside the block until their parent's costs have streamed past. When the region is complete the block presents a split-flag vector and a table with one mode per 8x8 position. It also gives a single-cycle completion strobe.

Top module: `qt_split_selector`

## Requirements
- R1: Each coding unit is delivered as 35 accepted beats, where beat k carries the cost of mode k (k = 0..34). A cycle with `costValid` low is not a beat and its `costData` has no effect.
- R2: The best mode of a unit is the mode with the smallest cost. When costs are equal, the lower mode index wins.
- R3: The 21 units of a region arrive in this order. For quadrant q = 0..3 (top-left, top-right, bottom-left, bottom-right), its four 8x8 units come first in the same Z order, then the 16x16 unit of that quadrant. The 32x32 unit is last.
- R4: A 16x16 unit is split exactly when its best cost is strictly greater than the sum of its four 8x8 best costs. If the two are equal, it is kept whole.
- R5: The structure cost of a quadrant is the sum of its children when the quadrant is split, and its own best cost otherwise. The 32x32 unit is split exactly when its best cost is strictly greater than the sum of the four structure costs.
- R6: `splitFlags` bit 0 is the 32x32 decision and bit 1+q is the decision for quadrant q. Bits 5..20 belong to the 8x8 units and are always 0. Any flag of a unit that lies inside an unsplit parent is 0.
- R7: `modeTable` bits [6p+5:6p] hold the best mode of the leaf unit that covers 8x8 position p, where p = 4q + c is the Z-order index of that position.
- R8: `done` is high for exactly one cycle, namely the cycle after the last beat of the 32x32 unit is accepted. The outputs change only together with `done` and then hold until the next `done`.
- R9: Right after reset, `splitFlags`, `modeTable` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| costValid | input | 1 | Marks a cycle that carries one mode cost |
| costData | input | COST_W | Distortion cost of the current mode of the current unit |
| splitFlags | output | 21 | Split decision per unit (32x32, four 16x16, sixteen 8x8) |
| modeTable | output | 96 | Sixteen 6-bit leaf modes, one per 8x8 position |
| done | output | 1 | One-cycle strobe when a region's decision is ready |

## Verification
The selector is tried with several kinds of region:
- Regions where the parents are cheap, so that nothing splits.
- Regions where parent and children cost exactly the same and where two modes tie. These tell a strict comparison apart from a non-strict one, and the lower-index rule apart from the opposite rule.
- Regions where every 16x16 unit splits but the 32x32 unit does not. These show whether flags inside an unsplit parent are cleared.
- Mixed and random regions with distinct modes per leaf. These expose errors in quadrant indexing and in table positions.

Idle cycles carrying a zero cost are mixed into the stream, and the outputs are compared against the previous result while the next region is streaming.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int NUM_MODES = 35;
  localparam int MODE_W = $clog2(NUM_MODES);
  localparam int CU_PER_QUAD = 5;
  localparam int NUM_QUAD = 4;
  localparam int NUM_CU = NUM_QUAD * CU_PER_QUAD + 1;
  localparam int CU_W = $clog2(NUM_CU);
  localparam int LEAF_N = NUM_QUAD * NUM_QUAD;
  localparam int FLAG_W = 1 + NUM_QUAD + LEAF_N;
  localparam int TBL_W = LEAF_N * MODE_W;

  typedef enum logic [1:0] {LVL8, LVL16, LVL32} lvl_t;

  typedef struct packed {
    logic              beat;
    logic              first;
    logic              last;
    lvl_t              lvl;
    logic [1:0]        quad;
    logic [1:0]        child;
    logic [MODE_W-1:0] mode;
  } qt_stb_t;
endpackage

// File: rtl/qt_split_ctrl.sv
module qt_split_ctrl
  import qt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    costValid,
  output qt_stb_t stb
);
  logic [MODE_W-1:0] modeCnt;
  logic [CU_W-1:0]   cuCnt;
  logic              lastMode;
  logic              lastCu;
  logic [CU_W-1:0]   base;
  logic [CU_W-1:0]   sub;

  assign lastMode = (modeCnt == MODE_W'(NUM_MODES - 1));
  assign lastCu   = (cuCnt == CU_W'(NUM_CU - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCnt <= '0;
      cuCnt   <= '0;
    end else if (costValid) begin
      if (lastMode) begin
        modeCnt <= '0;
        cuCnt   <= lastCu ? '0 : cuCnt + 1'b1;
      end else begin
        modeCnt <= modeCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb       = '0;
    stb.beat  = costValid;
    stb.first = costValid && (modeCnt == '0);
    stb.last  = costValid && lastMode;
    stb.mode  = modeCnt;
    base      = '0;
    for (int q = 1; q < NUM_QUAD; q++) begin
      if (cuCnt >= CU_W'(q * CU_PER_QUAD)) begin
        stb.quad = 2'(q);
        base     = CU_W'(q * CU_PER_QUAD);
      end
    end
    sub = cuCnt - base;
    if (lastCu) begin
      stb.lvl  = LVL32;
      stb.quad = '0;
    end else if (sub == CU_W'(CU_PER_QUAD - 1)) begin
      stb.lvl = LVL16;
    end else begin
      stb.lvl   = LVL8;
      stb.child = sub[1:0];
    end
  end
endmodule

// File: rtl/qt_split_dp.sv
module qt_split_dp
  import qt_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qt_stb_t           stb,
  input  logic [COST_W-1:0] costData,
  output logic [FLAG_W-1:0] splitFlags,
  output logic [TBL_W-1:0]  modeTable,
  output logic              done
);
  localparam int SUM8_W  = COST_W + 2;
  localparam int SUM16_W = COST_W + 4;

  logic [COST_W-1:0]  runCost;
  logic [MODE_W-1:0]  runMode;
  logic [COST_W-1:0]  leafCost  [NUM_QUAD];
  logic [MODE_W-1:0]  leafMode  [LEAF_N];
  logic [SUM8_W-1:0]  quadCost  [NUM_QUAD];
  logic [MODE_W-1:0]  quadMode  [NUM_QUAD];
  logic [NUM_QUAD-1:0] quadSplit;

  logic               takeNew;
  logic [COST_W-1:0]  curCost;
  logic [MODE_W-1:0]  curMode;
  logic [SUM8_W-1:0]  sum8;
  logic [SUM16_W-1:0] sum16;
  logic               split16Now;
  logic               split32Now;
  logic [SUM8_W-1:0]  quadCostNext;
  logic [FLAG_W-1:0]  flagsNext;
  logic [TBL_W-1:0]   tableNext;

  // running minimum over the mode stream, strict compare keeps lower index
  assign takeNew = stb.first || (costData < runCost);
  assign curCost = takeNew ? costData : runCost;
  assign curMode = takeNew ? stb.mode : runMode;

  always_comb begin
    sum8  = '0;
    sum16 = '0;
    for (int i = 0; i < NUM_QUAD; i++) begin
      sum8  = sum8 + SUM8_W'(leafCost[i]);
      sum16 = sum16 + SUM16_W'(quadCost[i]);
    end
  end

  assign split16Now   = SUM8_W'(curCost) > sum8;
  assign quadCostNext = split16Now ? sum8 : SUM8_W'(curCost);
  assign split32Now   = SUM16_W'(curCost) > sum16;

  always_comb begin
    flagsNext    = '0;
    flagsNext[0] = split32Now;
    for (int q = 0; q < NUM_QUAD; q++) begin
      flagsNext[1+q] = split32Now && quadSplit[q];
    end
  end

  generate
    for (genvar p = 0; p < LEAF_N; p++) begin : g_tbl
      localparam int Q = p / NUM_QUAD;
      assign tableNext[p*MODE_W +: MODE_W] =
        !split32Now  ? curMode :
        quadSplit[Q] ? leafMode[p] : quadMode[Q];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCost    <= '0;
      runMode    <= '0;
      quadSplit  <= '0;
      splitFlags <= '0;
      modeTable  <= '0;
      done       <= 1'b0;
      for (int i = 0; i < NUM_QUAD; i++) begin
        leafCost[i] <= '0;
        quadCost[i] <= '0;
        quadMode[i] <= '0;
      end
      for (int i = 0; i < LEAF_N; i++) leafMode[i] <= '0;
    end else begin
      done <= 1'b0;
      if (stb.beat) begin
        runCost <= curCost;
        runMode <= curMode;
      end
      if (stb.last) begin
        case (stb.lvl)
          LVL8: begin
            leafCost[stb.child]            <= curCost;
            leafMode[{stb.quad, stb.child}] <= curMode;
          end
          LVL16: begin
            quadCost[stb.quad]  <= quadCostNext;
            quadMode[stb.quad]  <= curMode;
            quadSplit[stb.quad] <= split16Now;
          end
          LVL32: begin
            splitFlags <= flagsNext;
            modeTable  <= tableNext;
            done       <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qt_split_selector.sv
module qt_split_selector
  import qt_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              costValid,
  input  logic [COST_W-1:0] costData,
  output logic [FLAG_W-1:0] splitFlags,
  output logic [TBL_W-1:0]  modeTable,
  output logic              done
);
  qt_stb_t stb;

  qt_split_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .costValid (costValid),
    .stb       (stb)
  );

  qt_split_dp #(.COST_W(COST_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .costData   (costData),
    .splitFlags (splitFlags),
    .modeTable  (modeTable),
    .done       (done)
  );
endmodule

// File: rtl/qt_split_checker.sv
module qt_split_checker
  import qt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [FLAG_W-1:0] splitFlags,
  input logic [TBL_W-1:0]  modeTable,
  input logic              done
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(splitFlags) && $stable(modeTable)));

  assert_leaf_flags_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (splitFlags[FLAG_W-1:1+NUM_QUAD] == '0));

  assert_unsplit_root_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !splitFlags[0]) |-> (splitFlags[NUM_QUAD:1] == '0));

  generate
    for (genvar p = 0; p < LEAF_N; p++) begin : g_pos
      assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rstN)
        done |-> (modeTable[p*MODE_W +: MODE_W] < MODE_W'(NUM_MODES)));

      assert_whole_root_uniform_R7: assert property (@(posedge clk) disable iff (!rstN)
        (done && !splitFlags[0]) |->
        (modeTable[p*MODE_W +: MODE_W] == modeTable[MODE_W-1:0]));

      assert_whole_quad_uniform_R7: assert property (@(posedge clk) disable iff (!rstN)
        (done && splitFlags[0] && !splitFlags[1 + p/NUM_QUAD]) |->
        (modeTable[p*MODE_W +: MODE_W] ==
         modeTable[(p/NUM_QUAD)*NUM_QUAD*MODE_W +: MODE_W]));
    end
  endgenerate
endmodule

bind qt_split_selector qt_split_checker u_qt_split_checker (
  .clk        (clk),
  .rstN       (rstN),
  .splitFlags (splitFlags),
  .modeTable  (modeTable),
  .done       (done)
);

// File: tb/test_qt_split_selector.sv
module test_qt_split_selector;
  import qt_pkg::*;
  localparam int COST_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              costValid = 1'b0;
  logic [COST_W-1:0] costData = '0;
  logic [FLAG_W-1:0] splitFlags;
  logic [TBL_W-1:0]  modeTable;
  logic              done;

  always #10 clk = ~clk;

  qt_split_selector #(.COST_W(COST_W)) i_qt_split_selector (
    .clk(clk), .rstN(rstN), .costValid(costValid), .costData(costData),
    .splitFlags(splitFlags), .modeTable(modeTable), .done(done)
  );

  typedef struct packed {
    logic [FLAG_W-1:0] f;
    logic [TBL_W-1:0]  t;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  int   costs [NUM_CU][NUM_MODES];
  exp_t expQ[$];
  exp_t prevExp;
  bit   havePrev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference from the requirements: strict minimum, strict split compares
  function automatic exp_t model();
    exp_t e;
    int best [NUM_CU];
    int bm   [NUM_CU];
    int qc   [NUM_QUAD];
    bit s16  [NUM_QUAD];
    int sum32;
    bit s32;
    for (int cu = 0; cu < NUM_CU; cu++) begin
      best[cu] = costs[cu][0];
      bm[cu]   = 0;
      for (int k = 1; k < NUM_MODES; k++)
        if (costs[cu][k] < best[cu]) begin
          best[cu] = costs[cu][k];
          bm[cu]   = k;
        end
    end
    sum32 = 0;
    for (int q = 0; q < NUM_QUAD; q++) begin
      int s8 = 0;
      for (int c = 0; c < 4; c++) s8 += best[q*CU_PER_QUAD + c];
      s16[q] = best[q*CU_PER_QUAD + 4] > s8;
      qc[q]  = s16[q] ? s8 : best[q*CU_PER_QUAD + 4];
      sum32 += qc[q];
    end
    s32  = best[NUM_CU-1] > sum32;
    e    = '0;
    e.f[0] = s32;
    for (int q = 0; q < NUM_QUAD; q++) e.f[1+q] = s32 && s16[q];
    for (int p = 0; p < LEAF_N; p++) begin
      int q = p / 4;
      int m;
      if (!s32)        m = bm[NUM_CU-1];
      else if (s16[q]) m = bm[q*CU_PER_QUAD + (p % 4)];
      else             m = bm[q*CU_PER_QUAD + 4];
      e.t[p*MODE_W +: MODE_W] = MODE_W'(m);
    end
    return e;
  endfunction

  task automatic setCu(input int cu, input int baseCost, input int m, input int c);
    for (int k = 0; k < NUM_MODES; k++) costs[cu][k] = baseCost;
    costs[cu][m] = c;
  endtask

  // driver: push expectation, stream the region with idle gaps (R1, R3)
  task automatic runRegion(input string name);
    exp_t e;
    e = model();
    expQ.push_back(e);
    for (int cu = 0; cu < NUM_CU; cu++) begin
      for (int k = 0; k < NUM_MODES; k++) begin
        if ((k % 7) == 3) begin
          @(negedge clk);
          costValid = 1'b0;
          costData  = '0;   // zero cost on an idle cycle must be ignored (R1)
        end
        @(negedge clk);
        if (havePrev && cu == 3 && k == 0)
          check({splitFlags, modeTable} == prevExp, "R8", {name, " hold"},
                128'({splitFlags, modeTable}), 128'(prevExp));
        costValid = 1'b1;
        costData  = COST_W'(costs[cu][k]);
      end
    end
    @(negedge clk);
    costValid = 1'b0;
    costData  = '0;
    check(done == 1'b1, "R8", {name, " done timing"}, 128'(done), 128'(1));
    prevExp  = e;
    havePrev = 1'b1;
  endtask

  // monitor: pop and compare on every done
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 128'(1), 128'(0));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(splitFlags == e.f, "R4 R5 R6", "split flags",
                128'(splitFlags), 128'(e.f));
          check(modeTable == e.t, "R2 R7", "mode table",
                128'(modeTable), 128'(e.t));
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", 128'(done), 128'(0));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 128'(0), 128'(1));
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(splitFlags == '0, "R9", "reset flags", 128'(splitFlags), 128'(0));
    check(modeTable == '0, "R9", "reset table", 128'(modeTable), 128'(0));
    check(done == 1'b0, "R9", "reset done", 128'(done), 128'(0));

    // cheap parents: nothing splits, every entry mode 5
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 4; c++) setCu(q*5 + c, 500, 5, 100);
      setCu(q*5 + 4, 500, 5, 50);
    end
    setCu(20, 500, 5, 30);
    runRegion("no split");

    // equal parent and children, two-way mode tie (R2, R4, R5)
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 4; c++) begin
        setCu(q*5 + c, 900, 20, 10);
        costs[q*5 + c][7] = 10;
      end
      setCu(q*5 + 4, 900, 3, 40);
    end
    setCu(20, 900, 9, 160);
    costs[20][30] = 160;
    runRegion("ties");

    // every level splits, distinct leaf modes to map positions (R7)
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 4; c++) setCu(q*5 + c, 900, q*4 + c + 2, 10);
      setCu(q*5 + 4, 900, 1, 41);
    end
    setCu(20, 900, 34, 161);
    runRegion("full split");

    // mixed quadrants under a split root
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 4; c++) setCu(q*5 + c, 900, 33 - (q*4 + c), 10);
      setCu(q*5 + 4, 900, 11 + q, (q % 2 == 0) ? 100 : 30);
    end
    setCu(20, 900, 0, 500);
    runRegion("mixed");

    // quadrants split but root kept whole: inner flags cleared (R6)
    for (int q = 0; q < 4; q++) begin
      for (int c = 0; c < 4; c++) setCu(q*5 + c, 900, c + 1, 10);
      setCu(q*5 + 4, 900, 8, 100);
    end
    setCu(20, 900, 22, 150);
    runRegion("root whole");

    for (int r = 0; r < 4; r++) begin
      for (int cu = 0; cu < NUM_CU; cu++) begin
        int lim;
        lim = (cu == 20) ? 16000 : ((cu % 5) == 4 ? 4000 : 1000);
        for (int k = 0; k < NUM_MODES; k++)
          costs[cu][k] = int'($urandom_range(lim, 0));
      end
      runRegion("random");
    end

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R8", "pending results", 128'(expQ.size()), 128'(0));
    summary();
  end
endmodule